// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock (SCK) of an SPI master from a faster module clock. A 13-bit control word holds two divider fields and a bit that selects between them. One law divides by an even ratio set by an 8-bit value. The other law divides by a power of two set by a 4-bit exponent. Software computes the field values from a target rate. That calculation is outside this block.

The transfer engine raises `en_i` for the length of a transfer. While `en_i` is low, SCK rests at the polarity level `cpol_i`, the internal counter stays cleared, and the block samples the control word on every cycle. While `en_i` is high, the sampled ratio stays fixed and SCK toggles once every half-period. A one-cycle `lead_o` strobe marks each transition away from the rest level. A one-cycle `trail_o` strobe marks each transition back to it. The shifter uses these strobes to decide when to drive and when to sample.

Top module: `spi_sck_divider`

## Requirements
- R1: While `rst_i` is high, `sck_o`, `lead_o` and `trail_o` are 0. While `en_i` is low, `lead_o` and `trail_o` stay 0, and `sck_o` takes the value `cpol_i` had on the previous clock edge.
- R2: When control bit 12 is 1 (linear law), SCK toggles every N2+1 module-clock cycles, where N2 = control bits 7:0. This gives SCK = clk / (2*(N2+1)), and N2=0 gives clk/2.
- R3: When control bit 12 is 0 (power-of-two law) and N1 = control bits 11:8 is 1 or more, SCK toggles every 2^(N1-1) cycles, so SCK = clk / 2^N1. N1=15 gives a half-period of 16384 cycles.
- R4: In the power-of-two law, N1=0 gives the same rate as N1=1: SCK toggles on every cycle.
- R5: After `en_i` rises, the first SCK transition follows the H-th rising clock edge at which `en_i` is high, where H is the half-period. Transitions then continue every H edges.
- R6: `lead_o` is high for exactly one cycle, the cycle in which `sck_o` has just moved away from `cpol_i`. It is never high at the same time as `trail_o`.
- R7: `trail_o` is high for exactly one cycle, the cycle in which `sck_o` has just returned to `cpol_i`.
- R8: The block samples the control word only while `en_i` is low. A change to the word while `en_i` is high leaves the running rate unchanged, and the new value applies to the next transfer.
- R9: When `en_i` falls in the middle of a half-period, `sck_o` returns to `cpol_i` after the next edge and no strobe fires.
- R10: Bit 12 alone chooses the law. With the same field values, flipping it switches between the N2+1 and the 2^(N1-1) half-periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run request from the transfer engine |
| cpol_i | input | 1 | SCK rest level |
| ctrl_i | input | 13 | Divider control: bit 12 law select, 11:8 exponent N1, 7:0 linear N2 |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on each transition away from the rest level |
| trail_o | output | 1 | One-cycle strobe on each transition back to the rest level |

## Verification
The hardest behaviour to reach from the ports is a change to the control word while SCK is running. It only reveals a fault when the new ratio would move the next transition. The directed stimulus rewrites the linear field in the middle of a transfer to a much larger value. It checks several more periods at the old rate, then drops `en_i` while SCK is away from its rest level, and confirms that the next transfer uses the new ratio. Random configurations of law, field values and polarity are checked cycle by cycle against a closed-form edge count. A directed run with the largest exponent covers the widest counter range.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    typedef enum logic {
        LAW_POW2 = 1'b0,
        LAW_LIN  = 1'b1
    } div_law_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_edge_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/div_ratio_sel.sv
module div_ratio_sel
    import spi_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int HW    = 15,
    localparam int CTRL_W = LIN_W + EXP_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              capture_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [HW-1:0]     half_o
);

    logic [LIN_W-1:0] lin_f;
    logic [EXP_W-1:0] exp_f;
    div_law_e         law;
    logic [HW-1:0]    half_nxt;

    assign lin_f = ctrl_i[LIN_W-1:0];
    assign exp_f = ctrl_i[LIN_W +: EXP_W];
    assign law   = div_law_e'(ctrl_i[CTRL_W-1]);

    always_comb begin
        if (law == LAW_LIN) begin
            half_nxt = HW'(lin_f) + HW'(1);
        end else if (exp_f == '0) begin
            half_nxt = HW'(1);
        end else begin
            half_nxt = HW'(1) << (exp_f - EXP_W'(1));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            half_o <= HW'(1);
        end else if (capture_i) begin
            half_o <= half_nxt;
        end
    end

endmodule

// File: rtl/div_tick.sv
module div_tick #(
    parameter int HW = 15
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic [HW-1:0] half_i,
    output logic          tick_o
);

    logic [HW-1:0] cnt;

    assign tick_o = run_i && (cnt == half_i - HW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

endmodule

// File: rtl/sck_gen.sv
module sck_gen
    import spi_div_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      run_i,
    input  logic      tick_i,
    input  logic      cpol_i,
    output logic      sck_o,
    output sck_edge_t edge_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sck_o  <= 1'b0;
            edge_o <= '0;
        end else if (!run_i) begin
            sck_o  <= cpol_i;
            edge_o <= '0;
        end else begin
            edge_o.lead  <= tick_i && (sck_o == cpol_i);
            edge_o.trail <= tick_i && (sck_o != cpol_i);
            if (tick_i) begin
                sck_o <= ~sck_o;
            end
        end
    end

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CTRL_W = LIN_W + EXP_W + 1,
    localparam int HW = int'(max_u(LIN_W + 1, (1 << EXP_W) - 1))
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              sck_o,
    output logic              lead_o,
    output logic              trail_o
);

    logic [HW-1:0] half;
    logic          tick;
    sck_edge_t     edges;

    div_ratio_sel #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HW(HW)) u_ratio (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_i (!en_i),
        .ctrl_i    (ctrl_i),
        .half_o    (half)
    );

    div_tick #(.HW(HW)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .half_i (half),
        .tick_o (tick)
    );

    sck_gen u_sck (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .tick_i (tick),
        .cpol_i (cpol_i),
        .sck_o  (sck_o),
        .edge_o (edges)
    );

    assign lead_o  = edges.lead;
    assign trail_o = edges.trail;

endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic cpol_i,
    input logic sck_o,
    input logic lead_o,
    input logic trail_o
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(en_i) |-> (!lead_o && !trail_o));

    // R1
    idle_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(en_i) |-> (sck_o == $past(cpol_i)));

    // R6
    lead_moves_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lead_o |-> (sck_o != $past(sck_o)) && (sck_o != cpol_i));

    // R6
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(lead_o && trail_o));

    // R6
    lead_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lead_o |=> !lead_o);

    // R7
    trail_moves_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        trail_o |-> (sck_o != $past(sck_o)) && (sck_o == cpol_i));

    // R5
    edge_flagged_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(en_i) && (sck_o != $past(sck_o))) |-> (lead_o || trail_o));

endmodule

bind spi_sck_divider spi_sck_divider_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .cpol_i  (cpol_i),
    .sck_o   (sck_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
);

// File: tb/sim_spi_sck_divider.sv
`timescale 1ns/1ps
module sim_spi_sck_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] ctrl = '0;
    logic        sck, lead, trail;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    spi_sck_divider u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .cpol_i(cpol),
        .ctrl_i(ctrl), .sck_o(sck), .lead_o(lead), .trail_o(trail)
    );

    function automatic int half_of(input logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        if (c[11:8] == 4'd0) return 1;
        return 1 << (int'(c[11:8]) - 1);
    endfunction

    // expected {sck, lead, trail} after k enabled edges
    function automatic logic [2:0] model(input int k, input int h, input logic p);
        int t = k / h;
        logic at = (k % h) == 0;
        return {p ^ t[0], at && t[0], at && !t[0]};
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {sck,lead,trail} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(tag, {sck, lead, trail}, {cpol, 2'b00});
    endtask

    task automatic run(input logic [12:0] c, input logic p, input int ncyc, input string tag);
        int h;
        @(negedge clk); en = 1'b0; ctrl = c; cpol = p;
        @(negedge clk); @(negedge clk);
        idle_chk("R1 idle level");
        h = half_of(c);
        en = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            chk(tag, {sck, lead, trail}, model(k, h, p));
        end
        en = 1'b0;
        @(negedge clk);
        idle_chk("R9 stop");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk); @(negedge clk);
        chk("R1 reset", {sck, lead, trail}, 3'b000);
        rst = 1'b0;

        // R2 linear, fastest and mid ratios
        run({1'b1, 4'd0, 8'd0}, 1'b0, 9, "R2 lin n2=0");
        run({1'b1, 4'd0, 8'd3}, 1'b1, 20, "R2 lin n2=3");
        run({1'b1, 4'd0, 8'd255}, 1'b0, 520, "R2 lin n2=255");
        // R3 power of two
        run({1'b0, 4'd3, 8'd0}, 1'b0, 20, "R3 pow n1=3");
        run({1'b0, 4'd15, 8'd0}, 1'b1, 2 * 16384 + 2, "R3 pow n1=15");
        // R4 N1=0 equals N1=1
        run({1'b0, 4'd0, 8'd9}, 1'b0, 7, "R4 pow n1=0");
        run({1'b0, 4'd1, 8'd9}, 1'b1, 7, "R4 pow n1=1");
        // R10 law select flips half-period with same fields
        run({1'b1, 4'd2, 8'd5}, 1'b0, 26, "R10 lin sel");
        run({1'b0, 4'd2, 8'd5}, 1'b0, 26, "R10 pow sel");

        // R8: field rewrite while running, R9: stop while SCK away from rest
        @(negedge clk); en = 1'b0; ctrl = {1'b1, 4'd0, 8'd2}; cpol = 1'b0;
        @(negedge clk); @(negedge clk);
        en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 4) ctrl = {1'b1, 4'd0, 8'd9};
            chk("R8 rate held", {sck, lead, trail}, model(k, 3, 1'b0));
        end
        @(negedge clk);
        chk("R5 pre-stop away", {sck, lead, trail}, model(17, 3, 1'b0));
        en = 1'b0;
        @(negedge clk);
        chk("R9 mid stop", {sck, lead, trail}, 3'b000);
        @(negedge clk);
        en = 1'b1;
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            chk("R8 new rate", {sck, lead, trail}, model(k, 10, 1'b0));
        end
        en = 1'b0;
        @(negedge clk);
        idle_chk("R9 stop");

        // random mix (R2, R3, R5, R6, R7)
        for (int i = 0; i < 24; i++) begin
            logic [12:0] c;
            logic p;
            c = '0;
            c[12] = 1'($urandom_range(0, 1));
            c[7:0] = 8'($urandom_range(0, 7));
            c[11:8] = 4'($urandom_range(0, 5));
            p = 1'($urandom_range(0, 1));
            run(c, p, 4 * half_of(c) + 3, "R5 R6 R7 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule